// File: doc/BRIEF.md
# Register Pending-Write Scoreboard

This block guards the dispatch stage of an in-order, single-issue pipeline whose functional units may finish out of order. It keeps a single pending-write flag per general-purpose register. A flag that is set means some instruction already sent to a functional unit has not yet written that register. A flag that is clear means the register file copy is current.

Each cycle the decoder offers one instruction: an optional destination index and two optional source indices. The block raises `disp_ready` only when none of the enabled sources is pending and the enabled destination is not pending. When `disp_valid` and `disp_ready` are both high, the instruction dispatches and its destination flag is set. An instruction that is refused stays at the port, so program order is kept. Several writeback ports report completed destinations, and those flags are cleared. A completion counts in the same cycle for the dispatch check.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every flag is clear, so any offered instruction gets `disp_ready` high.
- R2: When an enabled source (A or B) names a pending register, `hz_raw` is high and `disp_ready` is low.
- R3: When the enabled destination names a pending register, `hz_waw` is high and `disp_ready` is low.
- R4: A dispatch (`disp_valid` and `disp_ready` high, destination enabled) sets that destination's flag from the next cycle on.
- R5: A completion on any port (`wb_valid[p]` high, index in bits `wb_dst[p*5 +: 5]`) clears that register's flag from the next cycle on. Completions may arrive in any order.
- R6: A flag cleared by a completion in the same cycle counts as clear for that cycle's dispatch check.
- R7: A dispatch that sets one flag and completions that clear other flags in the same cycle all take effect.
- R8: A disabled destination or source field is not checked, whatever its index.
- R9: When `disp_valid` is low, or the instruction is stalled, no flag is set.
- R10: Up to four completion ports may clear distinct flags in the same cycle.
- R11: `disp_ready` depends only on the current flags, completions and fields, not on `disp_valid`. A stalled instruction therefore stays ready-checked each cycle until its hazards clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Decoded instruction present |
| disp_dst_en | input | 1 | Instruction writes a register |
| disp_dst | input | 5 | Destination index |
| disp_sa_en | input | 1 | Source A used |
| disp_sa | input | 5 | Source A index |
| disp_sb_en | input | 1 | Source B used |
| disp_sb | input | 5 | Source B index |
| disp_ready | output | 1 | No hazard; dispatch happens when valid |
| hz_raw | output | 1 | Source hazard present |
| hz_waw | output | 1 | Destination hazard present |
| wb_valid | input | 4 | Per-port completion strobe |
| wb_dst | input | 20 | Per-port completed destination, 5 bits each |

## Verification
A flag left set by mistake shows up as a permanent stall on the first later instruction that touches that register. A flag lost early shows up as `disp_ready` high while an older write is still outstanding. Both are visible in the very cycle the next instruction naming the register is offered. The bench therefore probes every register through source A, with `disp_valid` low, after each phase. It also runs a long mixed sequence against an arithmetic flag model, so every wrong flag is exposed within one probe sweep.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_NREG = 32;
  localparam int unsigned SB_NCMP = 4;
  localparam int unsigned SB_IDXW = 5;

  typedef enum logic [1:0] {
    HZ_NONE = 2'b00,
    HZ_RAW  = 2'b01,
    HZ_WAW  = 2'b10,
    HZ_BOTH = 2'b11
  } hz_kind_e;
endpackage

// File: rtl/sb_clear_merge.sv
module sb_clear_merge #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NCMP = 4,
  parameter int unsigned IDXW = 5
) (
  input  logic [NCMP-1:0]      wb_valid,
  input  logic [NCMP*IDXW-1:0] wb_dst,
  output logic [NREG-1:0]      clr_mask
);
  logic [NREG-1:0] port_mask [NCMP];

  for (genvar p = 0; p < NCMP; p++) begin : g_port
    always_comb begin
      port_mask[p] = '0;
      if (wb_valid[p]) port_mask[p][wb_dst[p*IDXW +: IDXW]] = 1'b1;
    end
  end

  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < NCMP; p++) clr_mask = clr_mask | port_mask[p];
  end
endmodule

// File: rtl/sb_pending_bits.sv
module sb_pending_bits #(
  parameter int unsigned NREG = 32,
  parameter int unsigned IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IDXW-1:0] set_idx,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] pend_q,
  output logic [NREG-1:0] pend_eff
);
  logic [NREG-1:0] pend_d;
  logic [NREG-1:0] set_mask;
  logic            upd_en;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
    pend_eff = pend_q & ~clr_mask;
    pend_d   = pend_eff | set_mask;
    upd_en   = set_en | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
  import sb_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned IDXW = 5
) (
  input  logic [NREG-1:0] pend_eff,
  input  logic            dst_en,
  input  logic [IDXW-1:0] dst,
  input  logic            sa_en,
  input  logic [IDXW-1:0] sa,
  input  logic            sb_en,
  input  logic [IDXW-1:0] sb,
  output logic            raw,
  output logic            waw,
  output logic            ok
);
  hz_kind_e kind;

  always_comb begin
    raw  = (sa_en & pend_eff[sa]) | (sb_en & pend_eff[sb]);
    waw  = dst_en & pend_eff[dst];
    kind = hz_kind_e'({waw, raw});
    ok   = (kind == HZ_NONE);
  end
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NREG = SB_NREG,
  parameter int unsigned NCMP = SB_NCMP,
  parameter int unsigned IDXW = SB_IDXW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic                 disp_dst_en,
  input  logic [IDXW-1:0]      disp_dst,
  input  logic                 disp_sa_en,
  input  logic [IDXW-1:0]      disp_sa,
  input  logic                 disp_sb_en,
  input  logic [IDXW-1:0]      disp_sb,
  output logic                 disp_ready,
  output logic                 hz_raw,
  output logic                 hz_waw,
  input  logic [NCMP-1:0]      wb_valid,
  input  logic [NCMP*IDXW-1:0] wb_dst
);
  logic [NREG-1:0] clr_mask;
  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_eff;
  logic            set_en;

  sb_clear_merge #(.NREG(NREG), .NCMP(NCMP), .IDXW(IDXW)) u_clr (
    .wb_valid (wb_valid),
    .wb_dst   (wb_dst),
    .clr_mask (clr_mask)
  );

  sb_hazard_check #(.NREG(NREG), .IDXW(IDXW)) u_hz (
    .pend_eff (pend_eff),
    .dst_en   (disp_dst_en),
    .dst      (disp_dst),
    .sa_en    (disp_sa_en),
    .sa       (disp_sa),
    .sb_en    (disp_sb_en),
    .sb       (disp_sb),
    .raw      (hz_raw),
    .waw      (hz_waw),
    .ok       (disp_ready)
  );

  assign set_en = disp_valid & disp_ready & disp_dst_en;

  sb_pending_bits #(.NREG(NREG), .IDXW(IDXW)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_en),
    .set_idx  (disp_dst),
    .clr_mask (clr_mask),
    .pend_q   (pend_q),
    .pend_eff (pend_eff)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NCMP = 4,
  parameter int unsigned IDXW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 disp_valid,
  input logic                 disp_dst_en,
  input logic [IDXW-1:0]      disp_dst,
  input logic                 disp_sa_en,
  input logic                 disp_sb_en,
  input logic                 disp_ready,
  input logic [NCMP-1:0]      wb_valid,
  input logic [NCMP*IDXW-1:0] wb_dst,
  input logic [NREG-1:0]      pend_q
);
  logic dst_cleared;
  logic fire;

  always_comb begin
    dst_cleared = 1'b0;
    for (int p = 0; p < NCMP; p++)
      if (wb_valid[p] && wb_dst[p*IDXW +: IDXW] == disp_dst) dst_cleared = 1'b1;
    fire = disp_valid & disp_ready;
  end

  // R4: dispatched destination is pending next cycle
  a_r4_dst_set: assert property (@(posedge clk) disable iff (!rst_n)
    fire && disp_dst_en |=> pend_q[$past(disp_dst)]);

  // R3: a pending destination that is not being cleared blocks dispatch
  a_r3_waw_block: assert property (@(posedge clk) disable iff (!rst_n)
    disp_dst_en && pend_q[disp_dst] && !dst_cleared |-> !disp_ready);

  // R8: nothing enabled means nothing to wait for
  a_r8_no_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_dst_en && !disp_sa_en && !disp_sb_en |-> disp_ready);

  // R9: no dispatch and no completion leaves the flags unchanged
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && wb_valid == '0 |=> $stable(pend_q));

  for (genvar p = 0; p < NCMP; p++) begin : g_clr
    // R5: completed destination is clear next cycle unless re-dispatched
    a_r5_wb_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[p] && !(fire && disp_dst_en && disp_dst == wb_dst[p*IDXW +: IDXW])
      |=> !pend_q[$past(wb_dst[p*IDXW +: IDXW])]);
  end
endmodule

bind reg_scoreboard sb_checker #(.NREG(NREG), .NCMP(NCMP), .IDXW(IDXW)) u_sb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_valid  (disp_valid),
  .disp_dst_en (disp_dst_en),
  .disp_dst    (disp_dst),
  .disp_sa_en  (disp_sa_en),
  .disp_sb_en  (disp_sb_en),
  .disp_ready  (disp_ready),
  .wb_valid    (wb_valid),
  .wb_dst      (wb_dst),
  .pend_q      (pend_q)
);

// File: tb/tb_reg_scoreboard.sv
module tb_reg_scoreboard;
  logic        clk;
  logic        rst_n;
  logic        disp_valid, disp_dst_en, disp_sa_en, disp_sb_en;
  logic [4:0]  disp_dst, disp_sa, disp_sb;
  logic        disp_ready, hz_raw, hz_waw;
  logic [3:0]  wb_valid;
  logic [19:0] wb_dst;

  int errors = 0;
  int checks = 0;
  logic [31:0] model;
  logic [15:0] lfsr;

  reg_scoreboard dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dst_en(disp_dst_en), .disp_dst(disp_dst),
    .disp_sa_en(disp_sa_en), .disp_sa(disp_sa),
    .disp_sb_en(disp_sb_en), .disp_sb(disp_sb),
    .disp_ready(disp_ready), .hz_raw(hz_raw), .hz_waw(hz_waw),
    .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle (after a falling edge), check the outputs, then let the
  // rising edge commit and update the model.
  task automatic step(input string tag, input logic v, input logic de, input logic [4:0] d,
                      input logic ae, input logic [4:0] a, input logic be, input logic [4:0] b,
                      input logic [3:0] wv, input logic [19:0] wd);
    logic [31:0] clr, eff;
    logic er, ew, ok;
    disp_valid = v; disp_dst_en = de; disp_dst = d;
    disp_sa_en = ae; disp_sa = a; disp_sb_en = be; disp_sb = b;
    wb_valid = wv; wb_dst = wd;
    #2;
    clr = '0;
    for (int p = 0; p < 4; p++) if (wv[p]) clr[wd[p*5 +: 5]] = 1'b1;
    eff = model & ~clr;
    er = (ae & eff[a]) | (be & eff[b]);
    ew = de & eff[d];
    ok = !er && !ew;
    chk({tag, " raw"}, hz_raw, er);
    chk({tag, " waw"}, hz_waw, ew);
    chk({tag, " ready"}, disp_ready, ok);
    @(posedge clk);
    model = eff;
    if (v && ok && de) model[d] = 1'b1;
    @(negedge clk);
  endtask

  task automatic probe_all(input string tag);
    for (int r = 0; r < 32; r++) step(tag, 1'b0, 1'b0, 5'd0, 1'b1, r[4:0], 1'b0, 5'd0, 4'h0, 20'h0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model = '0;
    rst_n = 1'b0;
    disp_valid = 0; disp_dst_en = 0; disp_sa_en = 0; disp_sb_en = 0;
    disp_dst = 0; disp_sa = 0; disp_sb = 0; wb_valid = 0; wb_dst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all registers free after reset
    probe_all("R1 reset");
    // R11: stalled-independent of valid; R4: dispatch all destinations
    for (int r = 0; r < 32; r++) step("R4 set", 1'b1, 1'b1, r[4:0], 1'b0, 5'd0, 1'b0, 5'd0, 4'h0, 20'h0);
    probe_all("R4 probe");
    // R2 on source B, R3 on destination, R9 stalled requests set nothing
    for (int r = 0; r < 32; r++) step("R2 srcb", 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, r[4:0], 4'h0, 20'h0);
    for (int r = 0; r < 32; r++) step("R3 dst", 1'b1, 1'b1, r[4:0], 1'b0, 5'd0, 1'b0, 5'd0, 4'h0, 20'h0);
    // R5 R10: clear 0..15 out of order, four ports per cycle
    for (int k = 0; k < 4; k++)
      step("R5 R10 clear", 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 4'hF,
           {5'(15 - k), 5'(3 - k), 5'(11 - k), 5'(7 - k)});
    probe_all("R5 probe");
    // R8: disabled fields naming pending registers are ignored
    step("R8 off", 1'b1, 1'b0, 5'd20, 1'b0, 5'd21, 1'b0, 5'd22, 4'h0, 20'h0);
    // R6 R7: sources and destination cleared this cycle; dispatch re-sets dst
    for (int k = 0; k < 8; k++)
      step("R6 R7 bypass", 1'b1, 1'b1, 5'(31 - k), 1'b1, 5'(23 - k), 1'b1, 5'(16 + k), 4'h7,
           {5'd0, 5'(31 - k), 5'(23 - k), 5'(16 + k)});
    probe_all("R7 probe");
    // R9: a stalled request (source pending) with free destination sets nothing
    step("R9 stalled", 1'b1, 1'b1, 5'd2, 1'b1, 5'd30, 1'b0, 5'd0, 4'h0, 20'h0);
    step("R9 idle", 1'b0, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 5'd0, 4'h0, 20'h0);
    probe_all("R9 probe");

    // Mixed sweep covering R2 R3 R4 R5 R6 R7 R11 against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] x;
      for (int j = 0; j < 4; j++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        x[j*16 +: 16] = lfsr;
      end
      step("R2 R3 R4 R5 sweep", x[0], x[1], x[6:2], x[7], x[12:8], x[13], x[18:14],
           x[22:19] & {3'b000, x[23]} | {x[24], x[25] & x[26], 1'b0, 1'b0}, x[47:28]);
    end
    probe_all("R11 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule